// File: doc/BRIEF.md
# Programmable Input Frame Offset Aligner

This block is the serial-input timing unit of a time-slot switch. An external frame pulse marks the start of every frame. Backplane routing can make the data on each serial input arrive a few bit periods after that pulse. The aligner runs one output bit/channel counter that stays locked to the frame pulse. For each input stream it also runs a separate input counter that restarts a programmed number of clock periods later. The result is a virtual input frame for each stream, aligned with the data actually arriving on it, while transmit framing is unchanged.

The block advances one bit position per clock cycle. A rate selector sets the frame length: 32 channels at the low rate, 64 at the medium rate and 128 at the high rate, each channel being 8 bits long. Each stream has a 3-bit offset field. The offset is honoured only at the medium and high rates. Offset values, and the rate that sets the frame length, are sampled in the cycle of the frame pulse and held for that frame.

Each stream is controlled by a four-state machine:
- IDLE: no frame pulse has been seen since reset.
- FIRST: the first offset countdown after leaving IDLE.
- RUN: aligned and sampling.
- SHIFT: the stream is still counting the old frame while the delay after a new pulse elapses.

The transitions are:
- IDLE→RUN or IDLE→FIRST on a pulse, depending on whether the offset is zero.
- FIRST→RUN when the countdown expires.
- RUN→SHIFT on a pulse with a non-zero offset.
- SHIFT→RUN when the countdown expires.
- SHIFT→SHIFT on a pulse that re-arms the countdown.

Top module: `frame_offset_aligner`

## Requirements
- R1: After reset, every input counter is 0, every sample enable is 0, and the output counter starts at 0.
- R2: The cycle after the frame pulse is high at a clock edge, the output position reads bit 0 of channel 0. The position then advances by one per clock: the bit index (0..7) runs first, and the channel index increments after bit 7.
- R3: With no further pulse, the output position wraps to 0 after the last bit of the frame. The frame holds 256 bit positions at rate_sel 0, 512 at rate_sel 1, and 1024 at rate_sel 2 or 3. The length used is the rate_sel value sampled at the most recent frame pulse.
- R4: At rate_sel 1, 2 or 3, an offset field value d from 1 to 4 makes that stream's input position reach 0 exactly d cycles after the output position does. After that, the input position equals the output position minus d.
- R5: An offset field of 0 makes the stream's input position equal to the output position from the cycle after the pulse onward.
- R6: Offset field values 5, 6 and 7 act exactly as 4.
- R7: At rate_sel 0, every offset field is ignored and every input position equals the output position.
- R8: An offset change written between frame pulses has no effect until the next frame pulse.
- R9: After reset, a stream's sample enable rises in the same cycle that its input position first restarts at 0. Once high, it stays high until reset.
- R10: Each stream's offset affects only that stream's input counters.
- R11: The output counters are unaffected by any offset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, one bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | One-cycle frame start marker |
| rate_sel | input | 2 | 0 low, 1 medium, 2 or 3 high rate |
| offset_cfg | input | 3*NUM_STREAMS | Per-stream offset fields; stream s occupies bits 3s+2..3s |
| out_bit | output | 3 | Output bit index within channel |
| out_ch | output | CH_W | Output channel index |
| in_bit | output | 3*NUM_STREAMS | Per-stream input bit index, stream s at bits 3s+2..3s |
| in_ch | output | CH_W*NUM_STREAMS | Per-stream input channel index |
| sample_en | output | NUM_STREAMS | Per-stream enable, high once the virtual frame is running |

## Verification
The assertions assume that the frame pulse is a single-cycle pulse, so each frame has one marker. They also assume that rate_sel and offset_cfg are only meaningful at the pulse edge. The bench drives the pulse for exactly one cycle at a time. It changes configuration only on falling clock edges, either before a pulse or in the middle of a frame to probe the latching rule. Every pulse gap is longer than the largest offset, so no countdown is re-armed by a pulse that comes too early.

// File: rtl/oa_pkg.sv
package oa_pkg;

    localparam int OFFSET_W  = 3;
    localparam int MAX_DELAY = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_RUN   = 2'd2,
        ST_SHIFT = 2'd3
    } aln_state_t;

    // Effective delay: disabled at low rate, saturated at MAX_DELAY
    function automatic logic [OFFSET_W-1:0] clamp_offset(
        input logic [1:0]          rate,
        input logic [OFFSET_W-1:0] raw
    );
        if (rate == 2'd0)
            return '0;
        else if (raw > OFFSET_W'(MAX_DELAY))
            return OFFSET_W'(MAX_DELAY);
        else
            return raw;
    endfunction

endpackage

// File: rtl/oa_frame_ctrl.sv
module oa_frame_ctrl #(
    parameter int BASE_CH = 32,
    parameter int POS_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic [1:0]       rate_sel,
    output logic [POS_W-1:0] out_pos,
    output logic [POS_W-1:0] pos_last
);

    localparam logic [POS_W-1:0] LAST_LO  = POS_W'(BASE_CH * 8 - 1);
    localparam logic [POS_W-1:0] LAST_MID = POS_W'(BASE_CH * 16 - 1);
    localparam logic [POS_W-1:0] LAST_HI  = POS_W'(BASE_CH * 32 - 1);

    logic [1:0]       act_rate_q;
    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_rate_q <= 2'd0;
            pos_q      <= '0;
        end else if (frame_pulse) begin
            act_rate_q <= rate_sel;
            pos_q      <= '0;
        end else if (pos_q >= pos_last) begin
            pos_q      <= '0;
        end else begin
            pos_q      <= pos_q + 1'b1;
        end
    end

    always_comb begin
        unique case (act_rate_q)
            2'd0:    pos_last = LAST_LO;
            2'd1:    pos_last = LAST_MID;
            default: pos_last = LAST_HI;
        endcase
    end

    assign out_pos = pos_q;

    // R2: frame start marker restarts the output frame
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (out_pos == '0));

    // R3: output position never leaves the active frame length
    a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_pos <= pos_last);

endmodule

// File: rtl/oa_stream_aligner.sv
module oa_stream_aligner
    import oa_pkg::*;
#(
    parameter int POS_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_pulse,
    input  logic [1:0]          rate_sel,
    input  logic [OFFSET_W-1:0] offset_raw,
    input  logic [POS_W-1:0]    pos_last,
    output logic [POS_W-1:0]    in_pos,
    output logic                sample_en
);

    aln_state_t          state_q, state_d;
    logic [OFFSET_W-1:0] left_q, left_d;
    logic [POS_W-1:0]    pos_q, pos_d;
    logic [OFFSET_W-1:0] eff_d;
    logic [POS_W-1:0]    pos_inc;

    assign eff_d   = clamp_offset(rate_sel, offset_raw);
    assign pos_inc = (pos_q >= pos_last) ? '0 : pos_q + 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            pos_q   <= pos_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE, ST_FIRST: begin
                if (frame_pulse) begin
                    if (eff_d == '0) begin
                        state_d = ST_RUN;
                        pos_d   = '0;
                    end else begin
                        state_d = ST_FIRST;
                        left_d  = OFFSET_W'(eff_d - 1'b1);
                    end
                end else if (state_q == ST_FIRST) begin
                    if (left_q == '0) begin
                        state_d = ST_RUN;
                        pos_d   = '0;
                    end else begin
                        left_d  = OFFSET_W'(left_q - 1'b1);
                    end
                end
            end
            ST_RUN: begin
                pos_d = pos_inc;
                if (frame_pulse) begin
                    if (eff_d == '0) begin
                        pos_d   = '0;
                    end else begin
                        state_d = ST_SHIFT;
                        left_d  = OFFSET_W'(eff_d - 1'b1);
                    end
                end
            end
            ST_SHIFT: begin
                pos_d = pos_inc;
                if (frame_pulse) begin
                    if (eff_d == '0) begin
                        state_d = ST_RUN;
                        pos_d   = '0;
                    end else begin
                        left_d  = OFFSET_W'(eff_d - 1'b1);
                    end
                end else if (left_q == '0) begin
                    state_d = ST_RUN;
                    pos_d   = '0;
                end else begin
                    left_d  = OFFSET_W'(left_q - 1'b1);
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        sample_en = (state_q == ST_RUN) || (state_q == ST_SHIFT);
        in_pos    = pos_q;
    end

    // R5: a zero effective offset restarts the virtual frame with the pulse
    a_r5_zero_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && eff_d == '0) |=> (in_pos == '0 && sample_en));

    // R9: once sampling, a stream keeps sampling
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> sample_en);

endmodule

// File: rtl/frame_offset_aligner.sv
module frame_offset_aligner
    import oa_pkg::*;
#(
    parameter  int NUM_STREAMS = 4,
    parameter  int BASE_CH     = 32,
    localparam int POS_W       = $clog2(BASE_CH * 32),
    localparam int CH_W        = POS_W - 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            frame_pulse,
    input  logic [1:0]                      rate_sel,
    input  logic [OFFSET_W*NUM_STREAMS-1:0] offset_cfg,
    output logic [2:0]                      out_bit,
    output logic [CH_W-1:0]                 out_ch,
    output logic [3*NUM_STREAMS-1:0]        in_bit,
    output logic [CH_W*NUM_STREAMS-1:0]     in_ch,
    output logic [NUM_STREAMS-1:0]          sample_en
);

    logic [POS_W-1:0] out_pos;
    logic [POS_W-1:0] pos_last;

    oa_frame_ctrl #(
        .BASE_CH (BASE_CH),
        .POS_W   (POS_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .rate_sel    (rate_sel),
        .out_pos     (out_pos),
        .pos_last    (pos_last)
    );

    assign out_bit = out_pos[2:0];
    assign out_ch  = out_pos[POS_W-1:3];

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        logic [POS_W-1:0] s_pos;

        oa_stream_aligner #(
            .POS_W (POS_W)
        ) u_aln (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_pulse (frame_pulse),
            .rate_sel    (rate_sel),
            .offset_raw  (offset_cfg[s*OFFSET_W +: OFFSET_W]),
            .pos_last    (pos_last),
            .in_pos      (s_pos),
            .sample_en   (sample_en[s])
        );

        assign in_bit[s*3 +: 3]       = s_pos[2:0];
        assign in_ch[s*CH_W +: CH_W]  = s_pos[POS_W-1:3];

        // R7: at low rate the virtual frame coincides with the output frame
        a_r7_low_rate: assert property (@(posedge clk) disable iff (!rst_n)
            (frame_pulse && rate_sel == 2'd0) |=> (s_pos == out_pos));
    end

endmodule

// File: tb/tb_frame_offset_aligner.sv
module tb_frame_offset_aligner;

    localparam int NS   = 4;
    localparam int CH_W = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic [3*NS-1:0] offset_cfg = '0;
    logic [2:0]    out_bit;
    logic [CH_W-1:0] out_ch;
    logic [3*NS-1:0] in_bit;
    logic [CH_W*NS-1:0] in_ch;
    logic [NS-1:0] sample_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    frame_offset_aligner #(.NUM_STREAMS(NS), .BASE_CH(32)) dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .rate_sel(rate_sel), .offset_cfg(offset_cfg),
        .out_bit(out_bit), .out_ch(out_ch), .in_bit(in_bit),
        .in_ch(in_ch), .sample_en(sample_en)
    );

    typedef struct packed {
        logic [1:0]  rate;
        logic [11:0] cfg;   // {s3,s2,s1,s0}
        logic [11:0] expd;  // expected delays, same packing
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{2'd1, {3'd0,3'd0,3'd0,3'd0}, {3'd0,3'd0,3'd0,3'd0}},
        '{2'd1, {3'd4,3'd3,3'd2,3'd1}, {3'd4,3'd3,3'd2,3'd1}},
        '{2'd2, {3'd1,3'd2,3'd3,3'd4}, {3'd1,3'd2,3'd3,3'd4}},
        '{2'd2, {3'd7,3'd6,3'd5,3'd4}, {3'd4,3'd4,3'd4,3'd4}},
        '{2'd0, {3'd4,3'd3,3'd2,3'd1}, {3'd0,3'd0,3'd0,3'd0}},
        '{2'd3, {3'd0,3'd5,3'd1,3'd2}, {3'd0,3'd4,3'd1,3'd2}},
        '{2'd0, {3'd7,3'd7,3'd7,3'd7}, {3'd0,3'd0,3'd0,3'd0}},
        '{2'd1, {3'd2,3'd0,3'd4,3'd7}, {3'd2,3'd0,3'd4,3'd4}}
    };

    function automatic int out_pos();
        return int'({out_ch, out_bit});
    endfunction

    function automatic int in_pos(input int s);
        return int'({in_ch[s*CH_W +: CH_W], in_bit[s*3 +: 3]});
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Returns at the falling edge right after the pulse edge (position 0)
    task automatic pulse();
        @(negedge clk) frame_pulse = 1'b1;
        @(negedge clk) frame_pulse = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "out_pos", out_pos(), 0);
        for (int s = 0; s < NS; s++) begin
            chk("R1", "in_pos", in_pos(s), 0);
            chk("R1", "sample_en", int'(sample_en[s]), 0);
        end
        repeat (5) @(negedge clk);
        chk("R9", "no pulse keeps sample_en low", int'(sample_en), 0);

        // R9: first virtual frame, stream 0 delayed by 3, others 0
        rate_sel   = 2'd1;
        offset_cfg = {3'd0, 3'd0, 3'd0, 3'd3};
        pulse();
        chk("R9", "s1 enabled at restart", int'(sample_en[1]), 1);
        chk("R9", "s1 pos", in_pos(1), 0);
        chk("R9", "s0 still waiting", int'(sample_en[0]), 0);
        repeat (2) @(negedge clk);
        chk("R9", "s0 waiting at 2", int'(sample_en[0]), 0);
        @(negedge clk);
        chk("R9", "s0 enabled at 3", int'(sample_en[0]), 1);
        chk("R4", "s0 restart at 3", in_pos(0), 0);

        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            rate_sel   = VEC[v].rate;
            offset_cfg = VEC[v].cfg;
            pulse();
            repeat (10) @(negedge clk);
            chk("R11", "out_pos", out_pos(), 10);
            for (int s = 0; s < NS; s++) begin
                int d;
                int raw;
                string req;
                d   = int'(VEC[v].expd[s*3 +: 3]);
                raw = int'(VEC[v].cfg[s*3 +: 3]);
                if (VEC[v].rate == 2'd0) req = "R7";
                else if (raw > 4)        req = "R6";
                else if (d == 0)         req = "R5";
                else                     req = "R4/R10";
                chk(req, "in_pos", in_pos(s), 10 - d);
                chk(req, "sample_en", int'(sample_en[s]), 1);
            end
        end

        // R2: bit-first counting inside a channel
        rate_sel = 2'd1; offset_cfg = '0;
        pulse();
        chk("R2", "bit at 0", int'(out_bit), 0);
        repeat (10) @(negedge clk);
        chk("R2", "bit at 10", int'(out_bit), 2);
        chk("R2", "ch at 10", int'(out_ch), 1);

        // R3: wrap at low rate (256 positions)
        rate_sel = 2'd0;
        pulse();
        repeat (255) @(negedge clk);
        chk("R3", "low last bit", int'(out_bit), 7);
        chk("R3", "low last ch", int'(out_ch), 31);
        @(negedge clk);
        chk("R3", "low wrap", out_pos(), 0);
        chk("R3", "low wrap in", in_pos(0), 0);

        // R3: wrap at high rate, rate change mid-frame ignored
        rate_sel = 2'd2;
        pulse();
        rate_sel = 2'd0;
        repeat (1023) @(negedge clk);
        chk("R3", "high last pos", out_pos(), 1023);
        @(negedge clk);
        chk("R3", "high wrap", out_pos(), 0);

        // R8: mid-frame offset change deferred to next pulse
        rate_sel = 2'd1; offset_cfg = {3'd0, 3'd0, 3'd0, 3'd2};
        pulse();
        repeat (2) @(negedge clk);
        offset_cfg = {3'd0, 3'd0, 3'd0, 3'd4};
        repeat (8) @(negedge clk);
        chk("R8", "old offset kept", in_pos(0), 8);
        chk("R10", "s1 unaffected", in_pos(1), 10);
        pulse();
        repeat (10) @(negedge clk);
        chk("R8", "new offset applied", in_pos(0), 6);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule